// File: doc/BRIEF.md
# Single-Address Accumulator Execution Unit

This block is a small sequential processor core. It executes one-address instructions against one accumulator. Every instruction word has an opcode and an address field. The accumulator is the implied second operand and the destination of every result. Instructions and data share one word-addressed memory port. The port uses a request/ready handshake, so the memory behind it may insert any number of wait states.

Each instruction runs through a fixed series of states:

- fetch, then decode;
- an operand read, when the opcode needs one;
- execute;
- a write-back, only for store and increment-and-skip.

The program counter and accumulator are visible as outputs. A halt flag reports that the unit has stopped. A sticky flag records any attempt to divide by zero.

Top module: `acc_exec_unit`

## Requirements
- R1: While reset is low and right after it, the unit shows pc = 0, acc = 0, halted = 0 and div_err = 0, and it requests a read of address 0.
- R2: An instruction word carries the opcode in bits [15:12] and the address field in bits [11:0]. Opcode 0x1 loads M[addr] into acc. Opcode 0x2 writes acc into M[addr] and leaves acc unchanged.
- R3: Opcode 0x3 sets acc to acc + M[addr], opcode 0x4 to acc - M[addr], and opcode 0x5 to the low 16 bits of acc * M[addr]. All arithmetic is two's complement.
- R4: Opcode 0x6 sets acc to the signed quotient acc / M[addr], truncated toward zero. A zero divisor leaves acc unchanged and sets div_err, which stays high until reset.
- R5: Opcode 0xB shifts acc right by one and fills with zero. Opcode 0xC shifts acc right by one and copies the sign bit. Opcode 0xD shifts acc left by one and fills with zero.
- R6: Opcode 0xE selects a single-operand operation with address bits [1:0]: 0 increments, 1 decrements, 2 negates, 3 takes the absolute value. The absolute value of 0x8000 is 0x8000.
- R7: Opcode 0x7 branches to addr when acc is zero. Opcode 0x8 branches when acc is nonzero with its sign bit clear. Opcode 0x9 branches when the sign bit is set. Opcode 0xF always branches. A branch that is not taken continues at pc + 1.
- R8: Opcode 0xA adds one to M[addr] and writes the result back. When the new value is zero, the next instruction is skipped (pc + 2); otherwise execution continues at pc + 1.
- R9: A memory request keeps mem_addr, mem_we and mem_wdata stable until a cycle in which mem_ready is high, and that cycle completes the access. Only opcodes 0x2 and 0xA write.
- R10: Opcode 0x0 raises halted, drops mem_req and holds pc at the address of that halt instruction until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 12 | Word address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid while mem_ready is high |
| mem_ready | input | 1 | Access completes at this clock edge |
| pc | output | 12 | Program counter |
| acc | output | 16 | Accumulator |
| halted | output | 1 | Halt instruction reached |
| div_err | output | 1 | Sticky divide-by-zero flag |

## Verification
The bench builds the unit with its default parameters: 16-bit words and a 4-bit opcode, which leaves a 12-bit address field. All opcodes are therefore reachable with short hand-written programs placed in the low 256 words of a bench memory. The memory model's response latency runs from zero to three wait cycles across the vector runs. This exposes any access that fails to hold its request stable or that completes without ready. Loop exit through increment-and-skip, the sign edges of branch-if-positive, and a divide by zero followed by a valid divide all fit in programs of a few words.

// File: rtl/acc_exec_unit.sv
module acc_exec_unit #(
  parameter int DATA_W = 16,
  parameter int OP_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [DATA_W-OP_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  input  logic [DATA_W-1:0]        mem_rdata,
  input  logic                     mem_ready,
  output logic [DATA_W-OP_W-1:0]   pc,
  output logic [DATA_W-1:0]        acc,
  output logic                     halted,
  output logic                     div_err
);
  localparam int ADDR_W = DATA_W - OP_W;

  localparam logic [OP_W-1:0] OP_HALT = OP_W'(4'h0);
  localparam logic [OP_W-1:0] OP_LOAD = OP_W'(4'h1);
  localparam logic [OP_W-1:0] OP_STOR = OP_W'(4'h2);
  localparam logic [OP_W-1:0] OP_ADD  = OP_W'(4'h3);
  localparam logic [OP_W-1:0] OP_SUB  = OP_W'(4'h4);
  localparam logic [OP_W-1:0] OP_MPY  = OP_W'(4'h5);
  localparam logic [OP_W-1:0] OP_DIV  = OP_W'(4'h6);
  localparam logic [OP_W-1:0] OP_BRZ  = OP_W'(4'h7);
  localparam logic [OP_W-1:0] OP_BRP  = OP_W'(4'h8);
  localparam logic [OP_W-1:0] OP_BRN  = OP_W'(4'h9);
  localparam logic [OP_W-1:0] OP_ISZ  = OP_W'(4'hA);
  localparam logic [OP_W-1:0] OP_SHR  = OP_W'(4'hB);
  localparam logic [OP_W-1:0] OP_SAR  = OP_W'(4'hC);
  localparam logic [OP_W-1:0] OP_SHL  = OP_W'(4'hD);
  localparam logic [OP_W-1:0] OP_UNI  = OP_W'(4'hE);
  localparam logic [OP_W-1:0] OP_JMP  = OP_W'(4'hF);

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_READ, S_EXEC, S_WRITE, S_HALT
  } state_t;

  state_t              state;
  logic [DATA_W-1:0]   ir;
  logic [DATA_W-1:0]   opnd;
  logic [DATA_W-1:0]   acc_q;
  logic [ADDR_W-1:0]   pc_q;
  logic                err_q;

  logic [OP_W-1:0]     op;
  logic [ADDR_W-1:0]   fld;
  logic                needs_opnd;
  logic                sign;
  logic                taken;
  logic [DATA_W-1:0]   acc_nx;
  logic                err_set;
  logic [DATA_W-1:0]   quot;

  assign op   = ir[DATA_W-1 -: OP_W];
  assign fld  = ir[ADDR_W-1:0];
  assign sign = acc_q[DATA_W-1];

  assign needs_opnd = (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) ||
                      (op == OP_MPY)  || (op == OP_DIV) || (op == OP_ISZ);

  assign taken = ((op == OP_BRZ) && (acc_q == '0)) ||
                 ((op == OP_BRP) && !sign && (acc_q != '0)) ||
                 ((op == OP_BRN) && sign) ||
                 (op == OP_JMP);

  assign quot = (opnd == '0) ? '0 : DATA_W'($signed(acc_q) / $signed(opnd));

  always_comb begin
    acc_nx  = acc_q;
    err_set = 1'b0;
    case (op)
      OP_LOAD: acc_nx = opnd;
      OP_ADD:  acc_nx = acc_q + opnd;
      OP_SUB:  acc_nx = acc_q - opnd;
      OP_MPY:  acc_nx = acc_q * opnd;
      OP_DIV: begin
        if (opnd == '0) err_set = 1'b1;
        else            acc_nx  = quot;
      end
      OP_SHR:  acc_nx = {1'b0, acc_q[DATA_W-1:1]};
      OP_SAR:  acc_nx = {sign, acc_q[DATA_W-1:1]};
      OP_SHL:  acc_nx = {acc_q[DATA_W-2:0], 1'b0};
      OP_UNI: begin
        case (fld[1:0])
          2'd0:    acc_nx = acc_q + DATA_W'(1);
          2'd1:    acc_nx = acc_q - DATA_W'(1);
          2'd2:    acc_nx = '0 - acc_q;
          default: acc_nx = sign ? ('0 - acc_q) : acc_q;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FETCH;
      ir    <= '0;
      opnd  <= '0;
      acc_q <= '0;
      pc_q  <= '0;
      err_q <= 1'b0;
    end else begin
      case (state)
        S_FETCH: if (mem_ready) begin
          ir    <= mem_rdata;
          state <= S_DECODE;
        end
        S_DECODE: begin
          if (op == OP_HALT)   state <= S_HALT;
          else if (needs_opnd) state <= S_READ;
          else                 state <= S_EXEC;
        end
        S_READ: if (mem_ready) begin
          opnd  <= mem_rdata;
          state <= S_EXEC;
        end
        S_EXEC: begin
          if (op == OP_STOR) begin
            state <= S_WRITE;
          end else if (op == OP_ISZ) begin
            opnd  <= opnd + DATA_W'(1);
            state <= S_WRITE;
          end else begin
            acc_q <= acc_nx;
            if (err_set) err_q <= 1'b1;
            pc_q  <= taken ? fld : pc_q + ADDR_W'(1);
            state <= S_FETCH;
          end
        end
        S_WRITE: if (mem_ready) begin
          pc_q  <= ((op == OP_ISZ) && (opnd == '0)) ? pc_q + ADDR_W'(2)
                                                    : pc_q + ADDR_W'(1);
          state <= S_FETCH;
        end
        S_HALT: ;
        default: state <= S_FETCH;
      endcase
    end
  end

  assign mem_req   = (state == S_FETCH) || (state == S_READ) || (state == S_WRITE);
  assign mem_we    = (state == S_WRITE);
  assign mem_addr  = (state == S_FETCH) ? pc_q : fld;
  assign mem_wdata = (op == OP_ISZ) ? opnd : acc_q;
  assign pc        = pc_q;
  assign acc       = acc_q;
  assign halted    = (state == S_HALT);
  assign div_err   = err_q;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_wdata)));

  // R9
  write_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_req && ((op == OP_STOR) || (op == OP_ISZ))));

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req);

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc) && $stable(acc)));

  // R4
  div_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |=> div_err);

endmodule

// File: tb/sim_acc_exec_unit.sv
module sim_acc_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req, mem_we, mem_ready;
  logic [11:0] mem_addr, pc;
  logic [15:0] mem_wdata, mem_rdata, acc;
  logic        halted, div_err;

  int checks = 0;
  int failures = 0;
  int lat = 0;
  int wcnt = 0;
  logic [15:0] mem [0:255];

  always #5 clk = ~clk;

  acc_exec_unit u0 (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .pc(pc), .acc(acc), .halted(halted),
    .div_err(div_err));

  initial begin
    mem_ready = 1'b0;
    mem_rdata = 16'h0000;
  end

  always @(negedge clk) begin
    if (!rst_n || mem_ready) begin
      mem_ready = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ready = 1'b1;
        if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
        else        mem_rdata = mem[mem_addr[7:0]];
      end else begin
        wcnt++;
      end
    end
  end

  // {acc start, instruction, operand at 0x81, expected acc}
  localparam logic [63:0] VEC [16] = '{
    64'h0005_3081_0007_000C,
    64'h0003_4081_000A_FFF9,
    64'h0123_5081_0100_2300,
    64'hFFFD_5081_0007_FFEB,
    64'h0064_6081_0007_000E,
    64'hFFF9_6081_0002_FFFD,
    64'h8003_B000_0000_4001,
    64'h8003_C000_0000_C001,
    64'h0007_C000_0000_0003,
    64'h4003_D000_0000_8006,
    64'hFFFF_E000_0000_0000,
    64'h0000_E001_0000_FFFF,
    64'h0005_E002_0000_FFFB,
    64'hFFF6_E003_0000_000A,
    64'h8000_E003_0000_8000,
    64'h0000_1081_1234_1234
  };

  function automatic string tag_of(int i);
    if (i <= 3)  return "R3 arith";
    if (i <= 5)  return "R4 divide";
    if (i <= 9)  return "R5 shift";
    if (i <= 14) return "R6 unary";
    return "R2 load";
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mem;
    for (int k = 0; k < 256; k++) mem[k] = 16'h0000;
  endtask

  task automatic run_prog(input int lat_i);
    bit done;
    rst_n = 1'b0;
    lat = lat_i;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    done = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (halted) begin
        done = 1'b1;
        break;
      end
    end
    chk("R10 halt reached", {15'd0, done}, 16'h0001);
  endtask

  task automatic run_branch(input logic [3:0] opc, input logic [15:0] val,
                            input bit tk, input string tag);
    clear_mem();
    mem[0] = 16'h1080;
    mem[1] = {opc, 12'h004};
    mem[2] = 16'h1081;
    mem[4] = 16'h1082;
    mem[8'h80] = val;
    mem[8'h81] = 16'h1111;
    mem[8'h82] = 16'h2222;
    run_prog(1);
    chk(tag, acc, tk ? 16'h2222 : 16'h1111);
    chk(tag, {4'h0, pc}, tk ? 16'h0005 : 16'h0003);
  endtask

  initial begin
    clear_mem();
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 pc", {4'h0, pc}, 16'h0000);
    chk("R1 acc", acc, 16'h0000);
    chk("R1 flags", {14'd0, halted, div_err}, 16'h0000);
    chk("R1 fetch req", {3'd0, mem_req, mem_addr}, 16'h1000);

    for (int i = 0; i < 16; i++) begin
      clear_mem();
      mem[0] = 16'h1080;
      mem[1] = VEC[i][47:32];
      mem[8'h80] = VEC[i][63:48];
      mem[8'h81] = VEC[i][31:16];
      run_prog(i % 4);
      chk(tag_of(i), acc, VEC[i][15:0]);
      chk("R4 no div_err", {15'd0, div_err}, 16'h0000);
      chk("R10 pc at halt", {4'h0, pc}, 16'h0002);
    end

    // R10: stays halted and quiet
    begin
      logic [11:0] pc0;
      bit bad;
      pc0 = pc;
      bad = 1'b0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (mem_req || !halted || pc != pc0) bad = 1'b1;
      end
      chk("R10 hold", {15'd0, bad}, 16'h0000);
    end

    // R2: store, acc unchanged; R9 write under wait states
    clear_mem();
    mem[0] = 16'h1080;
    mem[1] = 16'h2090;
    mem[8'h80] = 16'hBEEF;
    run_prog(3);
    chk("R2 store mem", mem[8'h90], 16'hBEEF);
    chk("R2 store acc", acc, 16'hBEEF);

    // R7: branches
    run_branch(4'h7, 16'h0000, 1'b1, "R7 brz taken");
    run_branch(4'h7, 16'h0005, 1'b0, "R7 brz not");
    run_branch(4'h8, 16'h0005, 1'b1, "R7 brp taken");
    run_branch(4'h8, 16'h0000, 1'b0, "R7 brp zero");
    run_branch(4'h8, 16'h8000, 1'b0, "R7 brp neg");
    run_branch(4'h9, 16'hFFFF, 1'b1, "R7 brn taken");
    run_branch(4'h9, 16'h0000, 1'b0, "R7 brn not");
    run_branch(4'hF, 16'h0005, 1'b1, "R7 jmp");

    // R8: loop counted by increment-and-skip
    clear_mem();
    mem[0] = 16'h1080;
    mem[1] = 16'h3081;
    mem[2] = 16'hA090;
    mem[3] = 16'hF001;
    mem[8'h80] = 16'h0000;
    mem[8'h81] = 16'h0001;
    mem[8'h90] = 16'hFFFD;
    run_prog(2);
    chk("R8 loop count", acc, 16'h0003);
    chk("R8 counter word", mem[8'h90], 16'h0000);
    chk("R8 skip pc", {4'h0, pc}, 16'h0004);

    // R4: divide by zero then valid divide, flag sticky
    clear_mem();
    mem[0] = 16'h1080;
    mem[1] = 16'h6081;
    mem[2] = 16'h6082;
    mem[8'h80] = 16'd77;
    mem[8'h81] = 16'h0000;
    mem[8'h82] = 16'd7;
    run_prog(0);
    chk("R4 div after zero", acc, 16'd11);
    chk("R4 sticky err", {15'd0, div_err}, 16'h0001);

    // R1: reset clears state left by previous program
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset acc", acc, 16'h0000);
    chk("R1 reset flags", {14'd0, halted, div_err}, 16'h0000);
    chk("R1 reset pc", {4'h0, pc}, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule